// File: doc/BRIEF.md
# Serial Configuration and Scan-Out Port

This block is the programming front end of a register-driven timing generator. A host writes 18-bit frames over three slow wires: a serial clock, a serial data line and a LOAD strobe. While LOAD is low, each rising serial clock edge captures one bit. When LOAD rises, the most recent frame is decoded. Low addresses write a 12-bit value into one of the configuration registers. These registers drive the generator's timing comparators through `cfg_o`.

A second range of addresses selects a register for read-back. A further three addresses select the live horizontal and vertical counters. Selecting any of these read-back addresses freezes the generator by dropping `run_en_o`. The chosen value is then shifted out on `sdout_o`, least significant bit first, once LOAD is high again. Read-back never alters any stored value. Sending any address that does not select a read-back target releases the generator, which carries on from the exact count at which it stopped.

All serial inputs are sampled in the system clock domain. The host must therefore hold each serial level for at least two system clocks.

Top module: `sp_scan_port`

## Requirements
- R1: The frame format is as follows. While LOAD is low, each rising edge of the serial clock shifts in one data bit. A frame is 18 bits sent address-first. The address occupies 6 bits and is sent LSB first. The 12-bit data field follows, also LSB first. On the rising edge of LOAD, the last 18 bits received form the frame. While LOAD is high, the serial clock shifts nothing in.
- R2: An address from 0 to 18 writes the data field into configuration register n. Register n appears on `cfg_o[12n+11:12n]`.
- R3: An address of 32+n, with n from 0 to 18, selects register n for read-back. One system clock after LOAD rises, `sdout_o` presents bit 0. Each further rising serial clock edge while LOAD is high advances the output to the next higher bit.
- R4: After the 12th bit of a read-back, every further serial clock edge keeps presenting the value's MSB.
- R5: A fresh read-back from bit 0 requires the read-back address to be accepted again by another LOAD rising edge. This applies even when the frame is unchanged.
- R6: Addresses 51, 52 and 53 read back the first horizontal count, the second horizontal count and the vertical count. Each count is sampled at the LOAD rising edge that accepts the address.
- R7: `sdout_o` is 0 whenever LOAD is low.
- R8: `run_en_o` is low from the cycle in which a read-back address is accepted until a non-read-back address is accepted. It is high at all other times.
- R9: A read-back leaves every configuration register unchanged. Repeated read-backs of a register return the same value.
- R10: Any address that is neither a write nor a read-back address releases the generator and writes nothing. These addresses are 19–31 and 54–63.
- R11: After reset, every configuration register is 0, `run_en_o` is 1 and `sdout_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, sampled |
| sdata_i | input | 1 | Serial data in |
| load_i | input | 1 | LOAD strobe; frame is taken on its rising edge |
| hcnt_a_i | input | 12 | First horizontal counter value |
| hcnt_b_i | input | 12 | Second horizontal counter value |
| vcnt_i | input | 12 | Vertical counter value |
| run_en_o | output | 1 | Counter clock enable for the generator |
| sdout_o | output | 1 | Serial read-back data |
| cfg_o | output | 228 | All configuration registers, register 0 in the low bits |

## Verification
The bench shifts beyond the twelfth bit of every read-back. This catches a design that wraps the value around or shifts in zeros instead of repeating the MSB. It reloads the same read-back address, and also drops and raises LOAD without new bits. A design that continued from the old position or kept driving `sdout_o` while LOAD was low would then give wrong bits. It reads the counters while they are frozen and checks that they stay put, then releases with unused addresses. This exposes a design that lets the generator run early, samples the counter one cycle late, or treats unused addresses as writes.

// File: rtl/sp_scan_pkg.sv
package sp_scan_pkg;
  // Action selected by the address field of a completed frame
  typedef enum logic [1:0] {
    ACT_NONE     = 2'd0,
    ACT_WRITE    = 2'd1,
    ACT_SCAN_REG = 2'd2,
    ACT_SCAN_CNT = 2'd3
  } sp_act_e;
endpackage

// File: rtl/sp_edge_det.sv
module sp_edge_det #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_n,
  input  logic sig_i,
  output logic rise_o
);
  logic sig_q;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) sig_q <= RST_VAL;
    else        sig_q <= sig_i;
  end

  assign rise_o = sig_i & ~sig_q;
endmodule

// File: rtl/sp_rx_shift.sv
module sp_rx_shift #(
  parameter int FRAME_W = 18
) (
  input  logic               clk_i,
  input  logic               rst_n,
  input  logic               shift_en,
  input  logic               bit_i,
  output logic [FRAME_W-1:0] frame_o
);
  logic [FRAME_W-1:0] frame_q, frame_d;

  // New bits enter at the top, so the first bit sent ends at bit 0
  always_comb begin
    frame_d = frame_q;
    if (shift_en) frame_d = {bit_i, frame_q[FRAME_W-1:1]};
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) frame_q <= '0;
    else        frame_q <= frame_d;
  end

  assign frame_o = frame_q;
endmodule

// File: rtl/sp_cfg_bank.sv
module sp_cfg_bank #(
  parameter int NUM_REGS = 19,
  parameter int DATA_W   = 12,
  parameter int IDX_W    = 5
) (
  input  logic                             clk_i,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [IDX_W-1:0]                 wr_idx,
  input  logic [DATA_W-1:0]                wr_data,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic              en;
    logic [DATA_W-1:0] val_q, val_d;

    assign en = wr_en && (wr_idx == IDX_W'(g));

    always_comb begin
      val_d = val_q;
      if (en) val_d = wr_data;
    end

    always_ff @(posedge clk_i or negedge rst_n) begin
      if (!rst_n) val_q <= '0;
      else        val_q <= val_d;
    end

    assign regs_o[g] = val_q;
  end
endmodule

// File: rtl/sp_tx_shift.sv
module sp_tx_shift #(
  parameter int DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [DATA_W-1:0] load_val,
  input  logic              shift_en,
  output logic [DATA_W-1:0] word_o
);
  logic [DATA_W-1:0] word_q, word_d;

  // Shift toward bit 0 while copying the MSB, so extra clocks repeat it
  always_comb begin
    word_d = word_q;
    if (load_en)       word_d = load_val;
    else if (shift_en) word_d = {word_q[DATA_W-1], word_q[DATA_W-1:1]};
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assign word_o = word_q;
endmodule

// File: rtl/sp_scan_port.sv
module sp_scan_port
  import sp_scan_pkg::*;
#(
  parameter int DATA_W        = 12,
  parameter int ADDR_W        = 6,
  parameter int NUM_REGS      = 19,
  parameter int REG_SCAN_BASE = 32,
  parameter int CNT_SCAN_BASE = 51
) (
  input  logic                        clk_i,
  input  logic                        rst_n_i,
  input  logic                        sclk_i,
  input  logic                        sdata_i,
  input  logic                        load_i,
  input  logic [DATA_W-1:0]           hcnt_a_i,
  input  logic [DATA_W-1:0]           hcnt_b_i,
  input  logic [DATA_W-1:0]           vcnt_i,
  output logic                        run_en_o,
  output logic                        sdout_o,
  output logic [NUM_REGS*DATA_W-1:0]  cfg_o
);
  localparam int FRAME_W = ADDR_W + DATA_W;
  localparam int IDX_W   = $clog2(NUM_REGS);
  localparam int NUM_CNT = 3;

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_n;
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) rst_pipe <= 2'b00;
    else          rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n = rst_pipe[1];

  logic sclk_rise, load_rise;
  sp_edge_det #(.RST_VAL(1'b0)) u_sclk_edge (
    .clk_i(clk_i), .rst_n(rst_n), .sig_i(sclk_i), .rise_o(sclk_rise));
  sp_edge_det #(.RST_VAL(1'b1)) u_load_edge (
    .clk_i(clk_i), .rst_n(rst_n), .sig_i(load_i), .rise_o(load_rise));

  logic               rx_shift;
  logic [FRAME_W-1:0] frame;
  assign rx_shift = sclk_rise & ~load_i;

  sp_rx_shift #(.FRAME_W(FRAME_W)) u_rx (
    .clk_i(clk_i), .rst_n(rst_n), .shift_en(rx_shift),
    .bit_i(sdata_i), .frame_o(frame));

  logic [ADDR_W-1:0] addr, reg_off, cnt_off;
  logic [DATA_W-1:0] wdata;
  assign addr    = frame[ADDR_W-1:0];
  assign wdata   = frame[FRAME_W-1:ADDR_W];
  assign reg_off = addr - ADDR_W'(REG_SCAN_BASE);
  assign cnt_off = addr - ADDR_W'(CNT_SCAN_BASE);

  sp_act_e act;
  always_comb begin
    act = ACT_NONE;
    if (int'(addr) < NUM_REGS)
      act = ACT_WRITE;
    else if (int'(addr) >= REG_SCAN_BASE && int'(addr) < REG_SCAN_BASE + NUM_REGS)
      act = ACT_SCAN_REG;
    else if (int'(addr) >= CNT_SCAN_BASE && int'(addr) < CNT_SCAN_BASE + NUM_CNT)
      act = ACT_SCAN_CNT;
  end

  logic is_scan, enter_scan, wr_en;
  assign is_scan    = (act == ACT_SCAN_REG) || (act == ACT_SCAN_CNT);
  assign enter_scan = load_rise & is_scan;
  assign wr_en      = load_rise & (act == ACT_WRITE);

  logic [NUM_REGS-1:0][DATA_W-1:0] regs;
  sp_cfg_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_bank (
    .clk_i(clk_i), .rst_n(rst_n), .wr_en(wr_en),
    .wr_idx(addr[IDX_W-1:0]), .wr_data(wdata), .regs_o(regs));
  assign cfg_o = regs;

  // Read-back source selection
  logic [DATA_W-1:0] scan_val;
  always_comb begin
    scan_val = '0;
    if (act == ACT_SCAN_REG) begin
      for (int i = 0; i < NUM_REGS; i++)
        if (reg_off[IDX_W-1:0] == IDX_W'(i)) scan_val = regs[i];
    end else if (act == ACT_SCAN_CNT) begin
      case (cnt_off[1:0])
        2'd0:    scan_val = hcnt_a_i;
        2'd1:    scan_val = hcnt_b_i;
        default: scan_val = vcnt_i;
      endcase
    end
  end

  // Scan mode state
  logic scan_q, scan_d;
  always_comb begin
    scan_d = scan_q;
    if (load_rise) scan_d = is_scan;
  end
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) scan_q <= 1'b0;
    else        scan_q <= scan_d;
  end

  logic              tx_shift;
  logic [DATA_W-1:0] tx_word;
  assign tx_shift = scan_q & load_i & sclk_rise;

  sp_tx_shift #(.DATA_W(DATA_W)) u_tx (
    .clk_i(clk_i), .rst_n(rst_n), .load_en(enter_scan),
    .load_val(scan_val), .shift_en(tx_shift), .word_o(tx_word));

  assign run_en_o = ~scan_q & ~enter_scan;
  assign sdout_o  = scan_q & load_i & tx_word[0];
endmodule

// File: rtl/sp_scan_port_chk.sv
module sp_scan_port_chk #(
  parameter int DATA_W   = 12,
  parameter int NUM_REGS = 19,
  parameter int FRAME_W  = 18
) (
  input logic                       clk_i,
  input logic                       rst_n,
  input logic                       load_i,
  input logic                       sdout_o,
  input logic                       run_en_o,
  input logic                       scan_q,
  input logic                       wr_en,
  input logic [NUM_REGS*DATA_W-1:0] cfg_o,
  input logic                       tx_shift,
  input logic                       tx_msb,
  input logic [FRAME_W-1:0]         frame
);
  // R7
  sdout_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !load_i |-> !sdout_o);

  // R8
  halt_in_scan_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    scan_q |-> !run_en_o);

  // R4
  msb_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    tx_shift |=> (tx_msb == $past(tx_msb)));

  // R9
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !wr_en |=> $stable(cfg_o));

  // R1
  rx_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    load_i |=> $stable(frame));
endmodule

bind sp_scan_port sp_scan_port_chk #(
  .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .FRAME_W(FRAME_W)
) chk_i (
  .clk_i(clk_i), .rst_n(rst_n), .load_i(load_i), .sdout_o(sdout_o),
  .run_en_o(run_en_o), .scan_q(scan_q), .wr_en(wr_en), .cfg_o(cfg_o),
  .tx_shift(tx_shift), .tx_msb(tx_word[DATA_W-1]), .frame(frame)
);

// File: tb/sp_scan_port_tb_top.sv
module sp_scan_port_tb_top;
  localparam int NR = 19;

  logic clk = 1'b0;
  logic rst_n, sclk, sdata, load;
  logic [11:0] ca, cb, cv;
  logic run_en, sdout;
  logic [NR*12-1:0] cfg;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [11:0] model [NR];

  always #5 clk = ~clk;

  sp_scan_port dut_i (
    .clk_i(clk), .rst_n_i(rst_n), .sclk_i(sclk), .sdata_i(sdata),
    .load_i(load), .hcnt_a_i(ca), .hcnt_b_i(cb), .vcnt_i(cv),
    .run_en_o(run_en), .sdout_o(sdout), .cfg_o(cfg));

  // Stand-in timing counters, gated by the block's enable
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ca <= 12'd0; cb <= 12'd100; cv <= 12'd7;
    end else if (run_en) begin
      ca <= ca + 12'd1; cb <= cb + 12'd3; cv <= cv + 12'd5;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_sclk();
    sclk = 1'b1;
    repeat (2) @(negedge clk);
    sclk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_frame(input logic [5:0] a, input logic [11:0] d);
    logic [17:0] f;
    f = {d, a};
    @(negedge clk);
    load = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 18; i++) begin
      sdata = f[i];
      pulse_sclk();
    end
    load = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic read_bits(input int n, output logic [14:0] bits);
    bits = '0;
    for (int i = 0; i < n; i++) begin
      bits[i] = sdout;
      pulse_sclk();
    end
  endtask

  function automatic logic [14:0] expect_bits(input logic [11:0] v);
    return {{3{v[11]}}, v};
  endfunction

  task automatic scan_reg(input int idx, input string req);
    logic [14:0] b;
    send_frame(6'(32 + idx), 12'($urandom));
    check({req, " run_en low"}, 32'(run_en), 32'd0);
    read_bits(15, b);
    check({req, " bits"}, 32'(b), 32'(expect_bits(model[idx])));
  endtask

  initial begin
    logic [14:0] b;
    logic [11:0] held;
    void'($urandom(32'd715));
    rst_n = 1'b0; sclk = 1'b0; sdata = 1'b0; load = 1'b1;
    for (int i = 0; i < NR; i++) model[i] = 12'd0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11: reset state
    check("R11 run_en", 32'(run_en), 32'd1);
    check("R11 sdout", 32'(sdout), 32'd0);
    check("R11 cfg", 32'(cfg[11:0]), 32'd0);
    scan_reg(0, "R11 R3");
    send_frame(6'd19, 12'hFFF);          // R10 unused address resumes
    check("R10 resume", 32'(run_en), 32'd1);
    check("R10 no write", 32'(cfg[18*12 +: 12]), 32'd0);

    // R2: directed writes
    send_frame(6'd18, 12'hA5C); model[18] = 12'hA5C;
    check("R2 reg18", 32'(cfg[18*12 +: 12]), 32'hA5C);
    send_frame(6'd0, 12'h801); model[0] = 12'h801;
    check("R2 reg0", 32'(cfg[11:0]), 32'h801);

    // R3 R4: read-back with extra clocks repeating MSB
    scan_reg(18, "R3 R4");
    // R5: reload the same address restarts at bit 0
    scan_reg(18, "R5 R9");
    // R7: LOAD low silences output; raising again rescans the same frame
    @(negedge clk); load = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 sdout low", 32'(sdout), 32'd0);
    load = 1'b1;
    repeat (3) @(negedge clk);
    read_bits(12, b);
    check("R5 rescan", 32'(b[11:0]), 32'hA5C);
    scan_reg(0, "R4 msb set");

    // R6 R8: live counter read-back while frozen
    send_frame(6'd60, 12'd0);            // R10 release
    check("R10 run_en", 32'(run_en), 32'd1);
    repeat (23) @(negedge clk);
    send_frame(6'd51, 12'd0);
    held = ca;
    read_bits(12, b);
    check("R6 hcnt_a", 32'(b[11:0]), 32'(held));
    check("R8 hold", 32'(ca), 32'(held));
    send_frame(6'd52, 12'd0);
    read_bits(12, b);
    check("R6 hcnt_b", 32'(b[11:0]), 32'(cb));
    send_frame(6'd53, 12'd0);
    read_bits(15, b);
    check("R6 vcnt", 32'(b), 32'(expect_bits(cv)));
    check("R8 still held", 32'(ca), 32'(held));
    send_frame(6'd25, 12'h123);          // R10 release, no write
    repeat (10) @(negedge clk);
    check("R8 run again", 32'(run_en), 32'd1);
    check("R8 advanced", 32'(ca != held), 32'd1);

    // Random mix
    for (int it = 0; it < 40; it++) begin
      int op, idx;
      logic [11:0] d;
      op  = int'($urandom_range(0, 2));
      idx = int'($urandom_range(0, NR - 1));
      d   = 12'($urandom);
      if (op == 0) begin
        send_frame(6'(idx), d); model[idx] = d;
        check("R2 random write", 32'(cfg[idx*12 +: 12]), 32'(d));
      end else if (op == 1) begin
        scan_reg(idx, "R3 random scan");
      end else begin
        send_frame(6'($urandom_range(54, 63)), d);
        check("R10 random resume", 32'(run_en), 32'd1);
      end
    end

    // R9 R10: full sweep against the model
    for (int i = 0; i < NR; i++) scan_reg(i, "R9 sweep");
    for (int i = 0; i < NR; i++)
      check("R9 cfg port", 32'(cfg[i*12 +: 12]), 32'(model[i]));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule